// File: doc/BRIEF.md
# ARINC 717 Subframe Sync Detector and Receive Buffer

This block takes an already-recovered serial bit stream, qualified by a one-cycle valid strobe per bit, and finds the 12-bit synchronisation code that opens each subframe. A frame is four subframes in a row. Each subframe opens with its own sync code, sent least significant bit first, and the code is followed by a fixed number of 12-bit data words. The block declares alignment only when a sync code is followed by the next code in the rotation at the exact spacing. It then cuts the stream into 12-bit words and writes them into a small receive FIFO that the host drains.

A raw mode skips sync detection entirely. In this mode the block reports itself as in sync and packs every 12 received bits into one FIFO word, with no word alignment. The FIFO reports full, half-full and empty, and it has a sticky overflow flag. A synchronous soft reset empties the FIFO and sends the detector back to hunting.

Top module: `a717_sync_rx`

## Requirements
- R1: After lock, each 12-bit word is assembled least significant bit first: the first bit received after a word boundary lands in bit 0 of the stored word.
- R2: The sync codes are 0x247, 0x5B8, 0xA47 and 0xDB8, in that rotation order, wrapping from 0xDB8 back to 0x247. in_sync_o rises only after a code is seen and the next code in the rotation follows exactly SF_DATA_WORDS data words later. Hunting may start at any of the four codes.
- R3: While not locked in sync mode, no word is written to the FIFO. The first word written after lock is the confirming sync code, and data words and later sync codes follow it.
- R4: A second code that is wrong, or that arrives at a spacing other than SF_DATA_WORDS data words, does not produce lock.
- R5: When locked, if the word at a sync position is not the expected code, in_sync_o clears at once, that word is not stored, and words already stored stay readable.
- R6: In raw mode (nosync_i=1), in_sync_o is 1. Every 12 valid bits, counted from the last soft reset, form one stored word, with the first bit in bit 0.
- R7: empty_o is 1 at zero words, half_o is 1 at FIFO_DEPTH/2 words or more, and full_o is 1 at FIFO_DEPTH words.
- R8: A write to a full FIFO drops the incoming word and sets ovf_o. ovf_o stays set until a read of a non-empty FIFO or a reset.
- R9: rd_data_o shows the oldest stored word. A pulse on rd_i while the FIFO is not empty removes that word, and words come out in arrival order.
- R10: soft_rst_i empties the FIFO and clears ovf_o, in_sync_o and the sync detection state.
- R11: After rst_ni is asserted, empty_o=1, and full_o, half_o, ovf_o and in_sync_o are 0.
- R12: Cycles with bit_vld_i=0 are ignored, whatever value bit_i has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous clear of FIFO and sync state |
| nosync_i | input | 1 | Raw mode: store bits without alignment |
| bit_i | input | 1 | Received data bit |
| bit_vld_i | input | 1 | bit_i is valid this cycle |
| rd_i | input | 1 | Pop the oldest FIFO word |
| rd_data_o | output | 12 | Oldest FIFO word (show-ahead) |
| in_sync_o | output | 1 | Word alignment established, or raw mode |
| full_o | output | 1 | FIFO full |
| half_o | output | 1 | FIFO at least half full |
| empty_o | output | 1 | FIFO empty |
| ovf_o | output | 1 | Sticky overflow |

## Verification
The bench builds the block with SF_DATA_WORDS=3 and FIFO_DEPTH=8. The short subframe lets lock, loss of lock, the rotation wrap from the last code to the first, and wrong-spacing rejection each finish within a few hundred bit times. The eight-word FIFO brings the half-full threshold, full, overflow drop and recovery within a few dozen words. The counters and comparisons are all written in terms of these parameters, so the default sizes use the same paths.

// File: rtl/a717_rx_pkg.sv
package a717_rx_pkg;
  localparam int WORD_W = 12;

  typedef enum logic [1:0] {ST_HUNT, ST_VERIFY, ST_LOCK} sync_st_e;

  function automatic logic [WORD_W-1:0] sync_code(input logic [1:0] idx);
    case (idx)
      2'd0:    return 12'h247;
      2'd1:    return 12'h5B8;
      2'd2:    return 12'hA47;
      default: return 12'hDB8;
    endcase
  endfunction
endpackage

// File: rtl/a717_word_framer.sv
module a717_word_framer
  import a717_rx_pkg::*;
#(
  parameter int SF_DATA_WORDS = 8191
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              nosync_i,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  output logic              wr_vld_o,
  output logic [WORD_W-1:0] wr_word_o,
  output logic              in_sync_o
);
  localparam int WCW = $clog2(SF_DATA_WORDS + 1);
  localparam int BCW = $clog2(WORD_W);
  localparam logic [WCW-1:0] WC_LAST = WCW'(SF_DATA_WORDS);
  localparam logic [BCW-1:0] BC_LAST = BCW'(WORD_W - 1);

  sync_st_e          st_q, st_d;
  logic [WORD_W-1:0] sr_q, sr_d;
  logic [BCW-1:0]    bcnt_q, bcnt_d;
  logic [WCW-1:0]    wcnt_q, wcnt_d;
  logic [1:0]        exp_q, exp_d;
  logic              wr_d, in_sync_d;
  logic [3:0]        hit;
  logic [1:0]        hit_idx;
  logic              word_done;

  // window including the bit arriving now, LSB first
  assign sr_d      = {bit_i, sr_q[WORD_W-1:1]};
  assign word_done = bit_vld_i && (bcnt_q == BC_LAST);

  for (genvar k = 0; k < 4; k++) begin : g_hit
    assign hit[k] = (sr_d == sync_code(2'(k)));
  end

  always_comb begin
    hit_idx = 2'd0;
    for (int k = 0; k < 4; k++) if (hit[k]) hit_idx = 2'(k);
  end

  always_comb begin
    st_d   = st_q;
    exp_d  = exp_q;
    bcnt_d = bcnt_q;
    wcnt_d = wcnt_q;
    wr_d   = 1'b0;
    if (bit_vld_i) bcnt_d = (bcnt_q == BC_LAST) ? '0 : bcnt_q + 1'b1;
    if (nosync_i) begin
      st_d = ST_HUNT;
      wr_d = word_done;
    end else if (bit_vld_i) begin
      unique case (st_q)
        ST_HUNT: if (|hit) begin
          st_d   = ST_VERIFY;
          exp_d  = hit_idx + 2'd1;
          bcnt_d = '0;
          wcnt_d = '0;
        end
        default: if (word_done) begin
          if (wcnt_q == WC_LAST) begin
            wcnt_d = '0;
            if (sr_d == sync_code(exp_q)) begin
              st_d  = ST_LOCK;
              exp_d = exp_q + 2'd1;
              wr_d  = 1'b1;
            end else begin
              st_d = ST_HUNT;
            end
          end else begin
            wcnt_d = wcnt_q + 1'b1;
            wr_d   = (st_q == ST_LOCK);
          end
        end
      endcase
    end
    in_sync_d = nosync_i || (st_d == ST_LOCK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_HUNT;
      sr_q      <= '0;
      bcnt_q    <= '0;
      wcnt_q    <= '0;
      exp_q     <= '0;
      wr_vld_o  <= 1'b0;
      wr_word_o <= '0;
      in_sync_o <= 1'b0;
    end else if (soft_rst_i) begin
      st_q      <= ST_HUNT;
      sr_q      <= '0;
      bcnt_q    <= '0;
      wcnt_q    <= '0;
      exp_q     <= '0;
      wr_vld_o  <= 1'b0;
      in_sync_o <= 1'b0;
    end else begin
      st_q      <= st_d;
      bcnt_q    <= bcnt_d;
      wcnt_q    <= wcnt_d;
      exp_q     <= exp_d;
      wr_vld_o  <= wr_d;
      in_sync_o <= in_sync_d;
      if (bit_vld_i) sr_q <= sr_d;
      if (wr_d) wr_word_o <= sr_d;
    end
  end
endmodule

// File: rtl/a717_rx_fifo.sv
module a717_rx_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_rst_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_i,
  output logic [W-1:0] rd_data_o,
  output logic         full_o,
  output logic         half_o,
  output logic         empty_o,
  output logic         ovf_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0] CNT_HALF = (AW+1)'(DEPTH / 2);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0]   cnt_q;
  logic          pop, push, drop;

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CNT_FULL);
  assign half_o    = (cnt_q >= CNT_HALF);
  assign rd_data_o = mem_q[rptr_q];
  assign pop       = rd_i && !empty_o;
  assign push      = wr_i && (!full_o || pop);
  assign drop      = wr_i && full_o && !pop;

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_o  <= 1'b0;
    end else if (soft_rst_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (push) wptr_q <= wptr_q + 1'b1;
      if (pop)  rptr_q <= rptr_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(push) - (AW+1)'(pop);
      ovf_o <= drop || (ovf_o && !pop);
    end
  end
endmodule

// File: rtl/a717_sync_rx.sv
module a717_sync_rx
  import a717_rx_pkg::*;
#(
  parameter int SF_DATA_WORDS = 8191,
  parameter int FIFO_DEPTH    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              nosync_i,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              in_sync_o,
  output logic              full_o,
  output logic              half_o,
  output logic              empty_o,
  output logic              ovf_o
);
  logic              fr_wr_vld;
  logic [WORD_W-1:0] fr_wr_word;

  a717_word_framer #(.SF_DATA_WORDS(SF_DATA_WORDS)) u_framer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst_i),
    .nosync_i  (nosync_i),
    .bit_i     (bit_i),
    .bit_vld_i (bit_vld_i),
    .wr_vld_o  (fr_wr_vld),
    .wr_word_o (fr_wr_word),
    .in_sync_o (in_sync_o)
  );

  a717_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst_i),
    .wr_i      (fr_wr_vld),
    .wr_data_i (fr_wr_word),
    .rd_i      (rd_i),
    .rd_data_o (rd_data_o),
    .full_o    (full_o),
    .half_o    (half_o),
    .empty_o   (empty_o),
    .ovf_o     (ovf_o)
  );
endmodule

// File: rtl/a717_sync_rx_chk.sv
module a717_sync_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic soft_rst_i,
  input logic rd_i,
  input logic wr_vld_i,
  input logic in_sync_o,
  input logic full_o,
  input logic empty_o,
  input logic ovf_o
);
  a_r7_full_not_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  a_r3_write_only_in_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_i |-> in_sync_o);

  a_r8_ovf_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_o && !soft_rst_i && !(wr_vld_i && full_o && !rd_i)) |=> !ovf_o);

  a_r8_ovf_clears_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && rd_i && !empty_o) |=> !ovf_o);

  a_r10_soft_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (empty_o && !ovf_o && !in_sync_o));
endmodule

bind a717_sync_rx a717_sync_rx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .soft_rst_i(soft_rst_i),
  .rd_i      (rd_i),
  .wr_vld_i  (fr_wr_vld),
  .in_sync_o (in_sync_o),
  .full_o    (full_o),
  .empty_o   (empty_o),
  .ovf_o     (ovf_o)
);

// File: tb/a717_sync_rx_tb.sv
`timescale 1ns/1ps
module a717_sync_rx_tb;
  localparam int SFD   = 3;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic soft_rst = 1'b0, nosync = 1'b0, bit_in = 1'b0, bit_vld = 1'b0, rd = 1'b0;
  logic [11:0] rd_data;
  logic in_sync, full, half, empty, ovf;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  a717_sync_rx #(.SF_DATA_WORDS(SFD), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .nosync_i(nosync),
    .bit_i(bit_in), .bit_vld_i(bit_vld), .rd_i(rd), .rd_data_o(rd_data),
    .in_sync_o(in_sync), .full_o(full), .half_o(half), .empty_o(empty), .ovf_o(ovf)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input bit gap);
    @(negedge clk);
    if (gap) begin
      bit_vld = 1'b0; bit_in = ~b;  // ignored cycle
      @(negedge clk);
    end
    bit_in = b; bit_vld = 1'b1;
  endtask

  task automatic send_word(input logic [11:0] w);
    for (int i = 0; i < 12; i++) send_bit(w[i], (i == 5));
  endtask

  task automatic idle(input int n);
    @(negedge clk); bit_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic pop_chk(input string req, input logic [11:0] exp);
    @(negedge clk);
    chk(req, rd_data, exp);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic do_soft_reset();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    idle(2);
  endtask

  task automatic t_reset();
    chk("R11 empty", 12'(empty), 12'd1);
    chk("R11 full", 12'(full), 12'd0);
    chk("R11 half", 12'(half), 12'd0);
    chk("R11 ovf", 12'(ovf), 12'd0);
    chk("R11 in_sync", 12'(in_sync), 12'd0);
  endtask

  task automatic t_lock();
    logic [11:0] d [9] = '{12'h011, 12'h0A5, 12'h3C0, 12'h123, 12'h456, 12'h789,
                            12'h0F1, 12'h2E2, 12'h6D3};
    nosync = 1'b0;
    do_soft_reset();
    for (int i = 0; i < 16; i++) send_bit(1'b0, 1'b0);
    send_word(12'hDB8);
    for (int i = 0; i < 3; i++) send_word(d[i]);
    idle(4);
    chk("R3 no lock after one code", 12'(in_sync), 12'd0);
    chk("R3 nothing stored before lock", 12'(empty), 12'd1);
    send_word(12'h247);  // R2 wrap from last code to first
    idle(4);
    chk("R2 lock on rotation", 12'(in_sync), 12'd1);
    chk("R3 sync stored", 12'(empty), 12'd0);
    for (int i = 3; i < 6; i++) send_word(d[i]);
    send_word(12'h5B8);
    idle(4);
    chk("R2 lock kept", 12'(in_sync), 12'd1);
    chk("R7 half at 5", 12'(half), 12'd1);
    chk("R7 not full at 5", 12'(full), 12'd0);
    pop_chk("R3 first word is sync", 12'h247);
    for (int i = 3; i < 6; i++) pop_chk("R1 R9 data word", d[i]);
    pop_chk("R9 next sync", 12'h5B8);
    chk("R9 empty after drain", 12'(empty), 12'd1);
    for (int i = 6; i < 9; i++) send_word(d[i]);
    send_word(12'hDB8);  // expected 0xA47
    idle(4);
    chk("R5 sync lost", 12'(in_sync), 12'd0);
    for (int i = 6; i < 9; i++) pop_chk("R5 prior data kept", d[i]);
    chk("R5 bad code dropped", 12'(empty), 12'd1);
  endtask

  task automatic t_no_false_lock();
    nosync = 1'b0;
    do_soft_reset();
    for (int i = 0; i < 16; i++) send_bit(1'b0, 1'b0);
    send_word(12'h5B8);
    for (int i = 0; i < 3; i++) send_word(12'h0C3);
    send_word(12'h5B8);  // wrong code
    idle(4);
    chk("R4 wrong code no lock", 12'(in_sync), 12'd0);
    chk("R4 wrong code nothing stored", 12'(empty), 12'd1);
    do_soft_reset();
    for (int i = 0; i < 16; i++) send_bit(1'b0, 1'b0);
    send_word(12'h247);
    for (int i = 0; i < 4; i++) send_word(12'h000);
    send_word(12'h5B8);  // one word late
    idle(4);
    chk("R4 wrong spacing no lock", 12'(in_sync), 12'd0);
    chk("R4 wrong spacing nothing stored", 12'(empty), 12'd1);
    for (int i = 0; i < 3; i++) send_word(12'h000);
    send_word(12'hA47);
    idle(4);
    chk("R2 relock on correct spacing", 12'(in_sync), 12'd1);
    pop_chk("R3 relock sync stored", 12'hA47);
    do_soft_reset();
    chk("R10 sync cleared", 12'(in_sync), 12'd0);
  endtask

  task automatic t_raw();
    nosync = 1'b1;
    do_soft_reset();
    chk("R6 in_sync in raw mode", 12'(in_sync), 12'd1);
    send_word(12'hABC);
    send_word(12'h247);
    idle(4);
    pop_chk("R6 R12 raw word 0", 12'hABC);
    pop_chk("R6 raw word 1", 12'h247);
    chk("R6 empty after raw", 12'(empty), 12'd1);
  endtask

  task automatic t_overflow();
    nosync = 1'b1;
    do_soft_reset();
    for (int k = 0; k < DEPTH + 1; k++) begin
      send_word(12'h300 + 12'(k));
      if (k == DEPTH/2 - 2) begin
        idle(4);
        chk("R7 half below threshold", 12'(half), 12'd0);
      end
      if (k == DEPTH/2 - 1) begin
        idle(4);
        chk("R7 half at threshold", 12'(half), 12'd1);
      end
    end
    idle(4);
    chk("R7 full", 12'(full), 12'd1);
    chk("R8 ovf set", 12'(ovf), 12'd1);
    idle(3);
    chk("R8 ovf sticky", 12'(ovf), 12'd1);
    pop_chk("R8 oldest kept", 12'h300);
    chk("R8 ovf cleared by read", 12'(ovf), 12'd0);
    for (int k = 1; k < DEPTH; k++) pop_chk("R8 R9 order", 12'h300 + 12'(k));
    chk("R8 extra word dropped", 12'(empty), 12'd1);
    for (int k = 0; k < 3; k++) send_word(12'h055);
    idle(4);
    do_soft_reset();
    chk("R10 fifo emptied", 12'(empty), 12'd1);
    chk("R10 ovf clear", 12'(ovf), 12'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_lock();
    t_no_false_lock();
    t_raw();
    t_overflow();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule